// File: doc/BRIEF.md
# Write-Back Three-State Snooping Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared, atomic snooping bus. Each cache line is held in one of three states: Invalid (no usable data), Shared (clean, read-only, possibly also held by other caches) or Exclusive (the only copy, writable and dirty with respect to memory). Processor requests that hit locally finish without touching the bus. Misses acquire the bus through a request/grant handshake and place a read-miss or write-miss transaction on it. If a dirty line with another tag has to be evicted first, the controller issues a write-back of that line before the miss.

On the snoop side, the controller watches every miss that another agent places on the bus. When it holds the only dirty copy of the requested line, it drives the line's data onto the bus in place of memory and raises an abort flag so that memory does not respond. It then downgrades the line to Shared on a read miss or drops it to Invalid on a write miss. A write miss that hits a Shared copy drops that copy to Invalid. When a snoop and a processor lookup target the same line in the same cycle, the snoop takes effect first and the lookup sees the updated state.

The FSM has three states. `FS_IDLE` waits for a processor strobe. `FS_CHECK` looks the request up against the post-snoop line state. `FS_BUS` holds a bus request, issuing a write-back and then the miss. The named transitions are: IDLE→CHECK on a request; CHECK→IDLE on a local hit; CHECK→BUS on a miss; BUS→BUS on a granted write-back; BUS→IDLE on a granted miss.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `bus_req` and `cpu_done` are low, and no snooped address makes the block supply data.
- R2: A processor read whose line is Invalid, or holds another tag, raises `bus_req` with `bus_cmd`=1 (read miss) and `bus_addr` equal to the request address. On grant, the line is filled from `bus_rdata` in state Shared and that data is returned on `cpu_rdata`.
- R3: A processor write whose line is Invalid, or Shared with any tag, raises `bus_req` with `bus_cmd`=2 (write miss). On grant, the line becomes Exclusive and holds the written data.
- R4: A read hit on a Shared or Exclusive line, and a write hit on an Exclusive line, finish with `cpu_done` two cycles after the strobe and with no bus request. The state is unchanged.
- R5: A miss whose line is Exclusive under another tag first issues `bus_cmd`=3 (write-back), with the victim's address ({victim tag, index}) and its latest data. The read or write miss follows, and the victim becomes Invalid.
- R6: A read miss that replaces a Shared line issues the read miss directly, with no write-back.
- R7: A snooped write miss that matches a Shared line makes it Invalid, so the next local access to it misses.
- R8: A snooped read miss that matches an Exclusive line raises `snp_supply` and `mem_abort` in the same cycle, with the line's data on `snp_data`. The line then becomes Shared.
- R9: A snooped write miss that matches an Exclusive line supplies its data and aborts memory in the same way. The line then becomes Invalid.
- R10: A snoop matches only when both index and tag agree. A snooped miss to another tag at the same index leaves the local line and its data untouched.
- R11: When a snoop and a processor lookup hit the same line in the same cycle, the snoop is applied first. The lookup then decides hit or miss on the updated state.
- R12: `bus_req` is held, with the command recomputed from current line state, until `bus_gnt`. A snooped write-back (`snp_cmd`=3) is ignored.
- R13: Across the system, at most one cache supplies a line at a time, and every processor read returns the most recently serialized write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle processor request strobe, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W+TAG_W | Request address {tag, index} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Bus grant; the transaction occurs at the edge where it is high |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | IDX_W+TAG_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data from memory or an intervening cache |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | IDX_W+TAG_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Supplied data |
| mem_abort | output | 1 | Tells memory to drop its response |

## Verification
The bench targets the following corner cases, each of which an incorrect design would get wrong in an observable way:
- A snoop arriving while the controller waits for its grant. Here a dirty victim may be downgraded by intervention, so a design that latched its command early would write back stale data or write back a line it no longer owns.
- A snoop landing in the lookup cycle. A design that checked the pre-snoop state would complete a write locally on a line another agent now shares, and a later read would return a stale value.
- A snoop to the same index with another tag. A design that compared only the index would invalidate or supply the wrong line.
- Replacement of clean lines. A design that wrote back Shared victims would emit spurious write-back transactions.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_CHECK = 2'd1,
        FS_BUS   = 2'd2
    } fsm_e;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              su_en,
    input  logic [IDX_W-1:0]  su_idx,
    input  line_st_e          su_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Snoop updates take priority over processor-side updates on the state.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]   <= LS_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else begin
                if (su_en && su_idx == IDX_W'(i)) begin
                    st_q[i] <= su_st;
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    st_q[i] <= wr_st;
                end
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    tag_q[i]  <= wr_tag;
                    data_q[i] <= wr_data;
                end
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              supply,
    output logic [DATA_W-1:0] sdata,
    output logic              upd_en,
    output line_st_e          upd_st
);
    logic match;

    assign match = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_tag);

    always_comb begin
        supply = 1'b0;
        upd_en = 1'b0;
        upd_st = ln_st;
        unique case (snp_cmd)
            BC_RDMISS: begin
                if (match && ln_st == LS_EXC) begin
                    supply = 1'b1;
                    upd_en = 1'b1;
                    upd_st = LS_SHR;
                end
            end
            BC_WRMISS: begin
                if (match) begin
                    supply = (ln_st == LS_EXC);
                    upd_en = 1'b1;
                    upd_st = LS_INV;
                end
            end
            default: begin
                supply = 1'b0;
            end
        endcase
    end

    assign sdata = supply ? ln_data : '0;

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [IDX_W+TAG_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    output logic [DATA_W-1:0]      cpu_rdata,
    output logic                   cpu_done,
    output logic                   bus_req,
    input  logic                   bus_gnt,
    output logic [1:0]             bus_cmd,
    output logic [IDX_W+TAG_W-1:0] bus_addr,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      bus_rdata,
    input  logic                   snp_valid,
    input  logic [1:0]             snp_cmd,
    input  logic [IDX_W+TAG_W-1:0] snp_addr,
    output logic                   snp_supply,
    output logic [DATA_W-1:0]      snp_data,
    output logic                   mem_abort
);
    localparam int ADDR_W = IDX_W + TAG_W;

    fsm_e              fsm_q, fsm_d;
    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    logic [IDX_W-1:0]  req_idx, snp_idx;
    logic [TAG_W-1:0]  req_tag, snp_tag;

    line_st_e          a_st, b_st, wr_st, su_st, eff_st;
    logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
    logic [DATA_W-1:0] a_data, b_data, wr_data, fin_data;
    logic              wr_en, su_en, fin;
    logic              tag_hit, local_hit, victim_dirty;
    bus_cmd_e          cmd_c;

    assign req_idx = req_addr_q[IDX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (req_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (snp_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .wr_en  (wr_en),
        .wr_idx (req_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .su_en  (su_en),
        .su_idx (snp_idx),
        .su_st  (su_st)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd  (bus_cmd_e'(snp_cmd)),
        .snp_tag  (snp_tag),
        .ln_st    (b_st),
        .ln_tag   (b_tag),
        .ln_data  (b_data),
        .supply   (snp_supply),
        .sdata    (snp_data),
        .upd_en   (su_en),
        .upd_st   (su_st)
    );

    assign mem_abort = snp_supply;

    // Lookup sees the line as it will be after a same-cycle snoop.
    assign eff_st       = (su_en && snp_idx == req_idx) ? su_st : a_st;
    assign tag_hit      = (a_tag == req_tag);
    assign local_hit    = tag_hit && ((eff_st == LS_EXC) ||
                                      (eff_st == LS_SHR && !req_we_q));
    assign victim_dirty = (a_st == LS_EXC) && !tag_hit;

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= FS_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            done_q      <= 1'b0;
        end else begin
            fsm_q  <= fsm_d;
            done_q <= fin;
            if (fin) begin
                rdata_q <= fin_data;
            end
            if (fsm_q == FS_IDLE && cpu_req) begin
                req_we_q    <= cpu_we;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        fsm_d     = fsm_q;
        fin       = 1'b0;
        fin_data  = '0;
        wr_en     = 1'b0;
        wr_st     = LS_INV;
        wr_tag    = req_tag;
        wr_data   = req_wdata_q;
        bus_req   = 1'b0;
        cmd_c     = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (fsm_q)
            FS_IDLE: begin
                if (cpu_req) begin
                    fsm_d = FS_CHECK;
                end
            end
            FS_CHECK: begin
                if (local_hit) begin
                    fin      = 1'b1;
                    fin_data = req_we_q ? req_wdata_q : a_data;
                    fsm_d    = FS_IDLE;
                    if (req_we_q) begin
                        wr_en = 1'b1;
                        wr_st = LS_EXC;
                    end
                end else begin
                    fsm_d = FS_BUS;
                end
            end
            FS_BUS: begin
                bus_req = 1'b1;
                if (victim_dirty) begin
                    cmd_c     = BC_WBACK;
                    bus_addr  = {a_tag, req_idx};
                    bus_wdata = a_data;
                    if (bus_gnt) begin
                        wr_en   = 1'b1;
                        wr_st   = LS_INV;
                        wr_tag  = a_tag;
                        wr_data = a_data;
                    end
                end else begin
                    cmd_c    = req_we_q ? BC_WRMISS : BC_RDMISS;
                    bus_addr = req_addr_q;
                    if (bus_gnt) begin
                        wr_en    = 1'b1;
                        wr_st    = req_we_q ? LS_EXC : LS_SHR;
                        wr_data  = req_we_q ? req_wdata_q : bus_rdata;
                        fin      = 1'b1;
                        fin_data = wr_data;
                        fsm_d    = FS_IDLE;
                    end
                end
            end
            default: begin
                fsm_d = FS_IDLE;
            end
        endcase
    end

    assign bus_cmd   = cmd_c;
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/msi_snoop_ctrl_sva.sv
module msi_snoop_ctrl_sva #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_supply
);

    // R1: quiet in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!bus_req && !cpu_done));

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R12: request held until granted
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R12: supply only answers a snooped miss
    a_r12_supply_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    // R5: a granted write-back is followed by the miss itself
    a_r5_wback_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd3) |=>
        (bus_req && bus_cmd != 2'd3 && bus_cmd != 2'd0));

    // R8: after intervention the line is no longer the dirty owner
    a_r8_no_second_supply: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> !(snp_valid && snp_supply && snp_addr == $past(snp_addr)));

    // R13: never completing while still requesting the bus
    a_r13_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .snp_supply(snp_supply)
);

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
    localparam int IW = 2;
    localparam int TW = 2;
    localparam int DW = 8;
    localparam int AW = IW + TW;
    localparam int NA = 1 << AW;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_done, bus_req;
    logic bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_supply, mem_abort;
    logic [DW-1:0] snp_data;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_supply(snp_supply), .snp_data(snp_data), .mem_abort(mem_abort)
    );

    // Reference: 0 Invalid, 1 Shared, 2 Exclusive
    logic [1:0]    rs [NL];
    logic [TW-1:0] rt [NL];
    logic [DW-1:0] mem [NA];
    logic [DW-1:0] gold [NA];
    bit            oown [NA];
    int checks = 0;
    int errors = 0;

    logic [1:0]    p_cmd;
    logic [AW-1:0] p_addr;
    logic          p_m, p_exp;
    logic [DW-1:0] p_nv;

    task automatic chk(input bit ok, input string r, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic logic [1:0] pick(input logic [AW-1:0] a);
        if (oown[a]) return 2'd3;
        return ($urandom % 2 == 0) ? 2'd1 : 2'd2;
    endfunction

    // Drive a snoop at a falling edge and check the combinational reply.
    task automatic snoop_drive(input logic [1:0] c, input logic [AW-1:0] a,
                               input string lbl);
        string l;
        int i;
        i = int'(a[IW-1:0]);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        p_m   = (rs[i] != 2'd0) && (rt[i] == a[AW-1:IW]);
        p_exp = (c == 2'd1 || c == 2'd2) && p_m && (rs[i] == 2'd2);
        if (lbl != "") l = lbl;
        else if (c == 2'd3) l = "R12";
        else if (rs[i] != 2'd0 && rt[i] != a[AW-1:IW]) l = "R10";
        else if (c == 2'd1) l = "R8";
        else if (p_exp) l = "R9";
        else l = "R7";
        chk(snp_supply == p_exp, l, "snp_supply", int'(snp_supply), int'(p_exp));
        chk(mem_abort == p_exp, l, "mem_abort", int'(mem_abort), int'(p_exp));
        if (p_exp) begin
            chk(snp_data == gold[a], l, "snp_data", int'(snp_data), int'(gold[a]));
            chk(!oown[a], "R13", "two dirty owners", 1, 0);
        end
        p_cmd = c; p_addr = a; p_nv = DW'($urandom);
    endtask

    task automatic snoop_commit();
        int i;
        i = int'(p_addr[IW-1:0]);
        if (p_cmd == 2'd1) begin
            if (p_exp) begin mem[p_addr] = gold[p_addr]; rs[i] = 2'd1; end
        end else if (p_cmd == 2'd2) begin
            if (p_exp) mem[p_addr] = gold[p_addr];
            if (p_m) rs[i] = 2'd0;
            oown[p_addr] = 1'b1;
            gold[p_addr] = p_nv;
        end else if (p_cmd == 2'd3) begin
            mem[p_addr] = gold[p_addr];
            oown[p_addr] = 1'b0;
        end
    endtask

    task automatic idle_snoop(input logic [1:0] c, input logic [AW-1:0] a,
                              input string lbl);
        snoop_drive(c, a, lbl);
        @(posedge clk);
        snoop_commit();
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic cpu_op(input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input bit inj,
                          input int maxdly);
        int i, cyc, dly;
        bit hit, saw, vict;
        logic [1:0] ec;
        logic [AW-1:0] ea, ra;
        string l;
        i = int'(a[IW-1:0]);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (inj) snoop_drive(pick(a), a, "R11");
        @(posedge clk);
        if (inj) snoop_commit();
        @(negedge clk);
        snp_valid = 1'b0;
        hit = (rs[i] != 2'd0) && (rt[i] == a[AW-1:IW]) &&
              ((rs[i] == 2'd2) || !we);
        saw = 1'b0; dly = 0; cyc = 0;
        while (!cpu_done && cyc < 64) begin
            cyc++;
            if (bus_req) begin
                saw  = 1'b1;
                vict = (rs[i] == 2'd2) && (rt[i] != a[AW-1:IW]);
                ec   = vict ? 2'd3 : (we ? 2'd2 : 2'd1);
                ea   = vict ? {rt[i], a[IW-1:0]} : a;
                if (vict) l = "R5";
                else if (!we && rs[i] == 2'd1) l = "R6";
                else if (we) l = "R3";
                else l = "R2";
                if (dly > 0) l = "R12";
                chk(bus_cmd == ec, l, "bus_cmd", int'(bus_cmd), int'(ec));
                chk(bus_addr == ea, l, "bus_addr", int'(bus_addr), int'(ea));
                if (vict) chk(bus_wdata == gold[ea], "R5", "wback data",
                              int'(bus_wdata), int'(gold[ea]));
                if (dly < maxdly) begin
                    dly++;
                    if ($urandom % 2 == 0) begin
                        ra = AW'($urandom);
                        idle_snoop(pick(ra), ra, "");
                    end else begin
                        @(negedge clk);
                    end
                end else begin
                    bus_gnt = 1'b1;
                    bus_rdata = oown[ea] ? gold[ea] : mem[ea];
                    @(posedge clk);
                    if (vict) begin
                        mem[ea] = bus_wdata;
                        rs[i] = 2'd0;
                    end else begin
                        if (oown[a]) begin mem[a] = gold[a]; oown[a] = 1'b0; end
                        rs[i] = we ? 2'd2 : 2'd1;
                        rt[i] = a[AW-1:IW];
                        if (we) gold[a] = wd;
                    end
                    dly = 0;
                    @(negedge clk);
                    bus_gnt = 1'b0;
                end
            end else begin
                @(negedge clk);
            end
        end
        chk(cpu_done == 1'b1, "R4", "completion", int'(cpu_done), 1);
        l = inj ? "R11" : (hit ? "R4" : (we ? "R3" : "R2"));
        chk(saw == !hit, l, "bus use", int'(saw), int'(!hit));
        if (hit && we) begin rs[i] = 2'd2; gold[a] = wd; end
        chk(cpu_rdata == (we ? wd : gold[a]), "R13", "read value",
            int'(cpu_rdata), int'(we ? wd : gold[a]));
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < NA; k++) begin
            mem[k] = DW'(k * 13 + 5); gold[k] = mem[k]; oown[k] = 1'b0;
        end
        for (int k = 0; k < NL; k++) begin rs[k] = 2'd0; rt[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req, "R1", "bus_req after reset", int'(bus_req), 0);
        chk(!cpu_done, "R1", "cpu_done after reset", int'(cpu_done), 0);
        for (int a = 0; a < NA; a++) idle_snoop(2'd1, AW'(a), "R1");
        // Per-address sweep: miss, hit, upgrade, hit, read hit.
        for (int a = 0; a < NA; a++) begin
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, a % 3);
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, 0);
            cpu_op(1'b1, AW'(a), DW'(a + 8'h40), 1'b0, 1);
            cpu_op(1'b1, AW'(a), DW'(a + 8'h80), 1'b0, 0);
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, 0);
        end
        // Same-index, other-tag snoops and intervention on dirty lines.
        for (int a = 0; a < NA; a++) begin
            cpu_op(1'b1, AW'(a), DW'(a ^ 8'h5a), 1'b0, 0);
            idle_snoop(pick(AW'(a ^ (1 << IW))), AW'(a ^ (1 << IW)), "R10");
            idle_snoop(2'd1, AW'(a), "R8");
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, 0);
            idle_snoop(2'd2, AW'(a), "R7");
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, 0);
            cpu_op(1'b1, AW'(a), DW'(a ^ 8'h33), 1'b0, 0);
            idle_snoop(2'd2, AW'(a), "R9");
            cpu_op(1'b0, AW'(a), 8'h00, 1'b0, 2);
        end
        // Same-cycle snoop and lookup.
        for (int a = 0; a < NA; a++) begin
            cpu_op(1'b1, AW'(a), DW'(a + 1), 1'b0, 0);
            cpu_op(1'b1, AW'(a), DW'(a + 2), 1'b1, 0);
            cpu_op(1'b0, AW'(a), 8'h00, 1'b1, 1);
        end
        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            if ($urandom % 4 == 0) idle_snoop(pick(ra), ra, "");
            cpu_op(1'($urandom), AW'($urandom), DW'($urandom),
                   ($urandom % 8 == 0), $urandom % 4);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule